// File: doc/BRIEF.md
# Edge-Latched Alarm Status Register

This block keeps a sticky record of changes on thirteen live status lines that come from an E1 receive framer. The lines cover frame, multiframe and CRC-4 alignment, remote CRC-4 indications and line alarms. Each line has one latch bit. A qualifying edge on the line sets that bit, and the bit then holds until software clears it. Each bit has a fixed edge rule. Some bits react to any change of their line. The others react only when their line goes from low to high.

Software reads the latch word through a strobe and a register select. A read returns the word as it stood before the read, and all latches clear at the end of that cycle. A read of the separate interrupt status register clears the latches in the same way. A single pending output tells the interrupt logic that at least one latch is set.

Top module: `alarm_edge_latch`

## Requirements
- R1: After reset, every latch is zero and `evt_pending` is low. A status line that is already high while reset is active is not counted as an edge when reset ends.
- R2: Bits 0, 1, 2, 7, 8, 9, 10 and 12 set to one on a rising edge of their status line and also on a falling edge.
- R3: Bits 3, 4, 5, 6 and 11 set to one only on a rising edge of their status line. A falling edge leaves them at zero.
- R4: A latch bit that is set stays at one, whatever its line does afterwards, until a clearing read.
- R5: When `host_rd` and `host_sel` are both high, `rd_data[12:0]` shows the latch values from before the read in that same cycle, and every latch is zero from the next cycle on.
- R6: A one-cycle pulse on `irq_rd` clears every latch from the next cycle on.
- R7: When `host_rd` is high and `host_sel` is low, `rd_data` is zero and no latch is cleared.
- R8: If a qualifying edge arrives in the same cycle as a clearing read, the bit for that edge is one after the clear.
- R9: `rd_data[15:13]` always reads zero.
- R10: `evt_pending` is high exactly when at least one latch bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_in | input | 13 | Live status lines, one per latch bit |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Selects this register for the host read |
| irq_rd | input | 1 | Strobe for a read of the interrupt status register |
| rd_data | output | 16 | Read data. Carries the latch word while this register is being read, zero otherwise |
| evt_pending | output | 1 | High while any latch is set |

## Verification
The hardest case to reach is an edge that falls in the same clock cycle as a clearing read. Neither the edge nor the clear can be allowed to win by accident. The bench creates this case by raising the read strobe and changing one status line at the same falling clock edge. It then confirms that the read returns the old word and that a second read returns only the new bit. A second hard case is a rising-only bit whose line falls. This case is visible only if the latches are cleared first. So the bench clears the latches, drops the line, and then reads back a zero.

// File: rtl/alarm_edge_latch.sv
module alarm_edge_latch #(
  parameter int NBITS = 13,
  parameter int DW    = 16,
  parameter logic [NBITS-1:0] ANY_EDGE = 13'b1_0111_1000_0111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] stat_in,
  input  logic             host_rd,
  input  logic             host_sel,
  input  logic             irq_rd,
  output logic [DW-1:0]    rd_data,
  output logic             evt_pending
);
  localparam int PAD = DW - NBITS;

  logic [NBITS-1:0] prev_q, lat_q, hit;
  logic             own_rd, clr;

  assign own_rd = host_rd & host_sel;
  assign clr    = own_rd | irq_rd;
  assign hit    = (stat_in & ~prev_q) | (~stat_in & prev_q & ANY_EDGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= stat_in;
      lat_q  <= '0;
    end else begin
      prev_q <= stat_in;
      lat_q  <= hit | (clr ? '0 : lat_q);
    end
  end

  assign rd_data     = own_rd ? {{PAD{1'b0}}, lat_q} : '0;
  assign evt_pending = |lat_q;
endmodule

module alarm_edge_latch_chk #(
  parameter int NBITS = 13,
  parameter int DW    = 16,
  parameter logic [NBITS-1:0] ANY_EDGE = 13'b1_0111_1000_0111
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBITS-1:0] stat_in,
  input logic             host_rd,
  input logic             host_sel,
  input logic             irq_rd,
  input logic [DW-1:0]    rd_data,
  input logic             evt_pending,
  input logic [NBITS-1:0] lat_q
);
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:NBITS] == '0);

  // R7
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_sel) |-> rd_data == '0);

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_sel) && !irq_rd |=> (lat_q & $past(lat_q)) == $past(lat_q));

  // R5
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd && host_sel) || irq_rd) && stat_in == $past(stat_in) |=> !evt_pending);

  // R8
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_in & ~$past(stat_in)) != '0 |=> evt_pending);

  // R3
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & ~$past(lat_q) & ~ANY_EDGE) & ~($past(stat_in) & ~$past(stat_in, 2))) == '0);
endmodule

bind alarm_edge_latch alarm_edge_latch_chk #(
  .NBITS(NBITS), .DW(DW), .ANY_EDGE(ANY_EDGE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .host_rd(host_rd),
  .host_sel(host_sel), .irq_rd(irq_rd), .rd_data(rd_data),
  .evt_pending(evt_pending), .lat_q(lat_q)
);

// File: tb/alarm_edge_latch_tb.sv
`timescale 1ns/1ps
module alarm_edge_latch_tb_top;
  localparam logic [12:0] BOTH = 13'b1_0111_1000_0111;

  logic        clk = 0, rst_n = 0, host_rd = 0, host_sel = 0, irq_rd = 0;
  logic [12:0] stat_in = '0;
  logic [15:0] rd_data;
  logic        evt_pending;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  alarm_edge_latch dut_i (
    .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .host_rd(host_rd),
    .host_sel(host_sel), .irq_rd(irq_rd), .rd_data(rd_data),
    .evt_pending(evt_pending)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [12:0] v);
    @(negedge clk); stat_in = v;
    @(negedge clk); #1;
  endtask

  task automatic rd_reg(output logic [15:0] v);
    @(negedge clk); host_rd = 1; host_sel = 1; #1 v = rd_data;
    @(negedge clk); host_rd = 0; host_sel = 0; #1;
  endtask

  task automatic flush();
    logic [15:0] v;
    rd_reg(v);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    stat_in = 13'h1FFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk); #1;
    check("R1 pending", {15'd0, evt_pending}, 16'd0);
    rd_reg(v);
    check("R1 latches", v, 16'd0);
    drive('0);
    flush();
  endtask

  task automatic t_both();
    logic [15:0] v;
    for (int b = 0; b < 13; b++) if (BOTH[b]) begin
      drive(13'd1 << b);
      rd_reg(v);
      check("R2 rise", v, 16'd1 << b);
      drive('0);
      rd_reg(v);
      check("R2 fall", v, 16'd1 << b);
    end
  endtask

  task automatic t_rise_only();
    logic [15:0] v;
    for (int b = 0; b < 13; b++) if (!BOTH[b]) begin
      drive(13'd1 << b);
      rd_reg(v);
      check("R3 rise", v, 16'd1 << b);
      drive('0);
      rd_reg(v);
      check("R3 fall ignored", v, 16'd0);
    end
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    drive(13'h0010);
    drive(13'h0000);
    repeat (5) @(negedge clk); #1;
    check("R4 pending held", {15'd0, evt_pending}, 16'd1);
    rd_reg(v);
    check("R4 sticky", v, 16'h0010);
  endtask

  task automatic t_host_clear();
    logic [15:0] v;
    drive(13'h0181);
    rd_reg(v);
    check("R5 pre-clear data", v, 16'h0181);
    rd_reg(v);
    check("R5 cleared", v, 16'h0000);
    drive('0);
    flush();
  endtask

  task automatic t_irq_clear();
    logic [15:0] v;
    drive(13'h0A05);
    @(negedge clk); irq_rd = 1;
    @(negedge clk); irq_rd = 0; #1;
    check("R6 pending after irq read", {15'd0, evt_pending}, 16'd0);
    rd_reg(v);
    check("R6 cleared", v, 16'h0000);
    drive('0);
    flush();
  endtask

  task automatic t_nosel();
    logic [15:0] v;
    drive(13'h0004);
    @(negedge clk); host_rd = 1; host_sel = 0; #1;
    check("R7 unselected data", rd_data, 16'h0000);
    @(negedge clk); host_rd = 0; #1;
    rd_reg(v);
    check("R7 not cleared", v, 16'h0004);
    drive('0);
    flush();
  endtask

  task automatic t_coincide();
    logic [15:0] v;
    drive(13'h0001);
    @(negedge clk); host_rd = 1; host_sel = 1; stat_in = 13'h0003; #1 v = rd_data;
    check("R8 read shows old", v, 16'h0001);
    @(negedge clk); host_rd = 0; host_sel = 0; #1;
    rd_reg(v);
    check("R8 edge kept", v, 16'h0002);
    drive('0);
    flush();
  endtask

  task automatic t_upper();
    logic [15:0] v;
    drive(13'h1FFF);
    check("R10 pending set", {15'd0, evt_pending}, 16'd1);
    rd_reg(v);
    check("R9 upper zero", {13'd0, v[15:13]}, 16'd0);
    check("R9 full word", v, 16'h1FFF);
    check("R10 pending clear", {15'd0, evt_pending}, 16'd0);
    drive('0);
    flush();
  endtask

  initial begin
    t_reset();
    t_both();
    t_rise_only();
    t_sticky();
    t_host_clear();
    t_irq_clear();
    t_nosel();
    t_coincide();
    t_upper();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule